// File: doc/BRIEF.md
# Radio Data Block and Group Synchroniser

This block takes a serial stream of demodulated data bits and finds where each 26-bit radio-data block starts and ends. Every 26 bits form a 16-bit information word and a 10-bit check word. Each time a bit arrives, the block computes the syndrome of the newest 26-bit window. It compares that syndrome with the five offset-word syndromes to tell which position in the group the window could hold.

A syndrome match on its own is weak evidence, because random bits match an offset about once in two hundred windows. For that reason the block declares lock only after a second match that comes exactly 26 bits after the first and carries the next position in the cyclic order A, B, C, D. Once it is locked, the block checks every 26th window. It passes each clean information word downstream with a two-bit position code. It counts damaged blocks and falls back to searching when too many of them fall inside one window of blocks.

The bit stream arrives in chunks with idle gaps between them. All synchronisation state (window contents, bit phase, expected position and error counts) is held in registers, so a lock gained in one chunk carries into the next. Both stream interfaces are valid/ready. A bit is taken on a clock edge only when `in_valid` and `in_ready` are both high. `in_ready` falls while an output word is held and not yet taken (`out_valid` high with `out_ready` low), so the sender has to wait. A word on the output stays unchanged until it is accepted.

Top module: `rds_group_sync`

## Requirements
- R1: After reset, `locked` and `out_valid` are 0 and `in_ready` is 1.
- R2: A block is sent most significant bit first: 16 info bits, then the check bits. The check word is (info·x^10 mod g) XOR the offset word, where g = x^10+x^8+x^7+x^5+x^4+x^3+1. The offset words are A=0x0FC, B=0x198, C=0x168, C'=0x350 and D=0x1B4. A window whose remainder mod g equals one of these offsets is recognised as that block.
- R3: Lock rises on the edge that accepts the last bit of a second block. That block must start exactly 26 accepted bits after a first recognised block and carry the next position (A→B→C→D→A). The second block is emitted on the same edge.
- R4: Two correctly spaced blocks in an illegal order (for example A followed by C) do not produce lock.
- R5: A recognised block followed by the next position shifted off the 26-bit spacing does not produce lock. Lock comes instead from the next correctly spaced pair.
- R6: While locked, every 26th accepted bit closes a block. A clean block is emitted with `out_data` equal to its info word and `out_type` equal to 0, 1, 2 or 3 for positions A, B, C/C' and D.
- R7: While locked, a block whose syndrome does not match the expected position is not emitted, and the expected position still advances.
- R8: Lock drops to search on the block that brings the count of bad blocks to MAX_BAD within the current window of WIN_BLOCKS blocks. The window starts at lock, and both counts restart every WIN_BLOCKS blocks.
- R9: `in_ready` is low while `out_valid` is high and `out_ready` is low. A stalled output word holds its data and type. Idle cycles with `in_valid` low change neither the lock state nor the bit phase.
- R10: At the third position, offset C' is accepted like C and reported as `out_type` 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A data bit is offered |
| in_ready | output | 1 | The block can accept a bit this cycle |
| in_bit | input | 1 | Serial data bit |
| out_valid | output | 1 | An information word is held on the output |
| out_ready | input | 1 | Downstream takes the held word |
| out_data | output | 16 | Information word of the emitted block |
| out_type | output | 2 | Position code: 0 A, 1 B, 2 C or C', 3 D |
| locked | output | 1 | Block and group synchronisation held |

## Verification
The main function is tried with several bit streams. A clean run of two groups, one of which uses C', exercises acquisition, position coding and the C' alias. A pair in an illegal order followed by a legal pair shows that order, not just a match, decides lock. A one-bit slip between two legal blocks shows that spacing is enforced. A locked stream carrying damaged blocks, first split across two error windows and then packed into one window, separates tolerated errors from a drop. A run with throttled `out_ready`, a long hold, and input gaps shows that words are neither lost nor altered under back-pressure and that lock survives idle periods.

// File: rtl/rds_sync_pkg.sv
`timescale 1ns/1ps
package rds_sync_pkg;

  // Code geometry
  localparam int BLK_LEN   = 26;
  localparam int INFO_W    = 16;
  localparam int CHK_W     = BLK_LEN - INFO_W;
  localparam int N_OFFSETS = 5;

  // Generator x^10+x^8+x^7+x^5+x^4+x^3+1
  localparam logic [CHK_W:0] GEN_POLY = 11'h5B9;

  // Position in a group; wraps A->B->C->D->A by 2-bit addition
  typedef logic [1:0] blk_pos_t;
  localparam blk_pos_t POS_A = 2'd0;
  localparam blk_pos_t POS_B = 2'd1;
  localparam blk_pos_t POS_C = 2'd2;
  localparam blk_pos_t POS_D = 2'd3;

  // Offset words; remainder of a clean block equals its offset
  localparam logic [CHK_W-1:0] OFS_TABLE [N_OFFSETS] =
    '{10'h0FC, 10'h198, 10'h168, 10'h350, 10'h1B4};
  localparam blk_pos_t POS_TABLE [N_OFFSETS] =
    '{POS_A, POS_B, POS_C, POS_C, POS_D};

  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } sync_state_t;

  // Remainder of a 26-bit window (first bit = highest power) modulo GEN_POLY
  function automatic logic [CHK_W-1:0] block_syndrome(input logic [BLK_LEN-1:0] word);
    logic [CHK_W-1:0] rem;
    logic             top;
    rem = '0;
    for (int i = BLK_LEN - 1; i >= 0; i--) begin
      top = rem[CHK_W-1];
      rem = {rem[CHK_W-2:0], word[i]};
      if (top) rem = rem ^ GEN_POLY[CHK_W-1:0];
    end
    return rem;
  endfunction

endpackage

// File: rtl/rds_bit_window.sv
`timescale 1ns/1ps
module rds_bit_window
  import rds_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic              win_full,
  output logic              hit,
  output blk_pos_t          hit_pos,
  output logic [INFO_W-1:0] info
);

  localparam int FILL_W = $clog2(BLK_LEN + 1);

  logic [BLK_LEN-1:0]   shreg;
  logic [BLK_LEN-1:0]   win_next;
  logic [FILL_W-1:0]    fill;
  logic [CHK_W-1:0]     syn;
  logic [N_OFFSETS-1:0] match;

  // Window as it will be once the offered bit is shifted in
  assign win_next = {shreg[BLK_LEN-2:0], bit_in};
  assign syn      = block_syndrome(win_next);
  assign info     = win_next[BLK_LEN-1 -: INFO_W];
  assign win_full = (fill >= FILL_W'(BLK_LEN - 1));

  generate
    for (genvar g = 0; g < N_OFFSETS; g++) begin : g_ofs
      assign match[g] = (syn == OFS_TABLE[g]);
    end
  endgenerate

  // Offsets are distinct, so at most one comparator fires
  always_comb begin
    hit     = |match;
    hit_pos = POS_A;
    for (int g = 0; g < N_OFFSETS; g++) begin
      if (match[g]) hit_pos = POS_TABLE[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      fill  <= '0;
    end else if (shift_en) begin
      shreg <= win_next;
      if (fill != FILL_W'(BLK_LEN)) fill <= fill + 1'b1;
    end
  end

endmodule

// File: rtl/rds_seq_ctrl.sv
`timescale 1ns/1ps
module rds_seq_ctrl
  import rds_sync_pkg::*;
#(
  parameter int WIN_BLOCKS = 8,
  parameter int MAX_BAD    = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  input  logic     win_full,
  input  logic     hit,
  input  blk_pos_t hit_pos,
  output logic     locked,
  output logic     emit,
  output blk_pos_t emit_pos
);

  localparam int CNT_W = $clog2(BLK_LEN);
  localparam int WIN_W = $clog2(WIN_BLOCKS + 1);
  localparam int BAD_W = $clog2(MAX_BAD + 1);

  sync_state_t      state, state_n;
  logic [CNT_W-1:0] bit_cnt, bit_cnt_n;
  blk_pos_t         expect_pos, expect_n;
  logic [WIN_W-1:0] blk_cnt, blk_n;
  logic [BAD_W-1:0] bad_cnt, bad_n;
  logic [WIN_W-1:0] blk_inc;
  logic [BAD_W-1:0] bad_inc;
  logic             boundary;
  logic             pos_ok;

  assign boundary = (bit_cnt == CNT_W'(BLK_LEN - 1));
  assign pos_ok   = hit && (hit_pos == expect_pos);
  assign blk_inc  = blk_cnt + 1'b1;
  assign bad_inc  = bad_cnt + 1'b1;

  always_comb begin
    state_n   = state;
    bit_cnt_n = bit_cnt;
    expect_n  = expect_pos;
    blk_n     = blk_cnt;
    bad_n     = bad_cnt;
    emit      = 1'b0;
    emit_pos  = expect_pos;
    if (step) begin
      unique case (state)
        ST_SEARCH: begin
          // Slide one bit at a time until some offset shows up
          if (win_full && hit) begin
            state_n   = ST_CONFIRM;
            bit_cnt_n = '0;
            expect_n  = hit_pos + 2'd1;
          end
        end
        ST_CONFIRM: begin
          if (!boundary) begin
            bit_cnt_n = bit_cnt + 1'b1;
          end else begin
            bit_cnt_n = '0;
            if (pos_ok) begin
              state_n  = ST_LOCKED;
              expect_n = expect_pos + 2'd1;
              blk_n    = '0;
              bad_n    = '0;
              emit     = 1'b1;
            end else if (hit) begin
              // Wrong order: restart the candidate from this block
              expect_n = hit_pos + 2'd1;
            end else begin
              state_n = ST_SEARCH;
            end
          end
        end
        ST_LOCKED: begin
          if (!boundary) begin
            bit_cnt_n = bit_cnt + 1'b1;
          end else begin
            bit_cnt_n = '0;
            expect_n  = expect_pos + 2'd1;
            if (pos_ok) begin
              emit = 1'b1;
            end
            if (!pos_ok && (bad_inc >= BAD_W'(MAX_BAD))) begin
              state_n = ST_SEARCH;
              blk_n   = '0;
              bad_n   = '0;
            end else if (blk_inc == WIN_W'(WIN_BLOCKS)) begin
              blk_n = '0;
              bad_n = '0;
            end else begin
              blk_n = blk_inc;
              bad_n = pos_ok ? bad_cnt : bad_inc;
            end
          end
        end
        default: state_n = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_SEARCH;
      bit_cnt    <= '0;
      expect_pos <= POS_A;
      blk_cnt    <= '0;
      bad_cnt    <= '0;
      locked     <= 1'b0;
    end else begin
      state      <= state_n;
      bit_cnt    <= bit_cnt_n;
      expect_pos <= expect_n;
      blk_cnt    <= blk_n;
      bad_cnt    <= bad_n;
      locked     <= (state_n == ST_LOCKED);
    end
  end

endmodule

// File: rtl/rds_word_out.sv
`timescale 1ns/1ps
module rds_word_out
  import rds_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [INFO_W-1:0] load_info,
  input  blk_pos_t          load_pos,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [INFO_W-1:0] out_data,
  output blk_pos_t          out_type,
  output logic              stall
);

  assign stall = out_valid && !out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_type  <= POS_A;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_info;
      out_type  <= load_pos;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rds_group_sync.sv
`timescale 1ns/1ps
module rds_group_sync
  import rds_sync_pkg::*;
#(
  parameter int WIN_BLOCKS = 8,
  parameter int MAX_BAD    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_bit,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_data,
  output logic [1:0]  out_type,
  output logic        locked
);

  logic              step;
  logic              win_full;
  logic              hit;
  blk_pos_t          hit_pos;
  logic [INFO_W-1:0] info;
  logic              emit;
  blk_pos_t          emit_pos;
  logic              stall;

  assign in_ready = !stall;
  assign step     = in_valid && in_ready;

  rds_bit_window u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (step),
    .bit_in   (in_bit),
    .win_full (win_full),
    .hit      (hit),
    .hit_pos  (hit_pos),
    .info     (info)
  );

  rds_seq_ctrl #(
    .WIN_BLOCKS (WIN_BLOCKS),
    .MAX_BAD    (MAX_BAD)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .win_full (win_full),
    .hit      (hit),
    .hit_pos  (hit_pos),
    .locked   (locked),
    .emit     (emit),
    .emit_pos (emit_pos)
  );

  rds_word_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (emit),
    .load_info (info),
    .load_pos  (emit_pos),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_type  (out_type),
    .stall     (stall)
  );

endmodule

// File: rtl/rds_group_sync_chk.sv
`timescale 1ns/1ps
module rds_group_sync_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_data,
  input logic [1:0]  out_type,
  input logic        locked
);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_type)));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  idle_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(locked));

  // R3
  lock_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> out_valid);

  // R6
  word_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> locked);

endmodule

bind rds_group_sync rds_group_sync_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_type  (out_type),
  .locked    (locked)
);

// File: tb/rds_group_sync_test.sv
`timescale 1ns/1ps
module rds_group_sync_test;

  localparam logic [9:0] OA = 10'h0FC, OB = 10'h198, OC = 10'h168, OCP = 10'h350, OD = 10'h1B4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_bit = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic [1:0]  out_type;
  logic        locked;

  always #2 clk = ~clk;

  rds_group_sync #(.WIN_BLOCKS(8), .MAX_BAD(3)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_type(out_type), .locked(locked)
  );

  typedef struct {
    logic [15:0] data;
    logic [1:0]  typ;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   cyc      = 0;
  int   nbits    = 0;
  bit   bp_mode  = 0;
  bit   hold     = 0;
  bit   gap_mode = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Long division by the generator, high bit first
  function automatic logic [9:0] mod_gen(input logic [25:0] v);
    logic [25:0] r;
    r = v;
    for (int i = 25; i >= 10; i--) begin
      if (r[i]) r = r ^ (26'h5B9 << (i - 10));
    end
    return r[9:0];
  endfunction

  function automatic logic [25:0] mk_block(input logic [15:0] d, input logic [9:0] ofs);
    return {d, mod_gen({d, 10'b0}) ^ ofs};
  endfunction

  // Monitor: drives out_ready and compares every transfer with the scoreboard
  always @(negedge clk) begin
    cyc++;
    out_ready = hold ? 1'b0 : (bp_mode ? ((cyc % 3) != 0) : 1'b1);
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check(0, "R7", "unexpected output word", int'(out_data), 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check((out_data == e.data) && (out_type == e.typ), e.tag, "output word/type",
              int'({out_type, out_data}), int'({e.typ, e.data}));
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk);
    in_valid = 1'b1;
    in_bit   = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    nbits++;
    if (gap_mode && (nbits % 5 == 0)) begin
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic send_block(input logic [15:0] d, input logic [9:0] ofs, input bit emit,
                            input logic [1:0] typ, input string tag, input bit damage);
    logic [25:0] blk;
    blk = mk_block(d, ofs);
    if (damage) blk = blk ^ 26'h80;
    if (emit) begin
      exp_t e;
      e.data = d;
      e.typ  = typ;
      e.tag  = tag;
      sb.push_back(e);
    end
    for (int i = 25; i >= 0; i--) send_bit(blk[i]);
  endtask

  task automatic check_lock(input logic exp, input string tag);
    check(locked == exp, tag, "lock flag", int'(locked), int'(exp));
  endtask

  task automatic drain(input string tag);
    repeat (30) @(negedge clk);
    check(sb.size() == 0, tag, "words still pending", sb.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    hold     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    @(negedge clk);
    #1;
    check(locked == 1'b0, "R1", "lock after reset", int'(locked), 0);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // R2, R3, R6, R10: two clean groups, second uses C'
    send_block(16'h1234, OA, 0, 2'd0, "R2", 0);
    check_lock(1'b0, "R3");
    send_block(16'hABCD, OB, 1, 2'd1, "R3", 0);
    check_lock(1'b1, "R3");
    send_block(16'h0F0F, OC, 1, 2'd2, "R6", 0);
    send_block(16'hFFFF, OD, 1, 2'd3, "R6", 0);
    send_block(16'h0000, OA, 1, 2'd0, "R6", 0);
    send_block(16'h8001, OB, 1, 2'd1, "R2", 0);
    send_block(16'h5A5A, OCP, 1, 2'd2, "R10", 0);
    send_block(16'hC3C3, OD, 1, 2'd3, "R6", 0);
    check_lock(1'b1, "R6");
    drain("R6");

    // R4: illegal A then C, then a legal C then D
    do_reset();
    send_block(16'h2468, OA, 0, 2'd0, "R4", 0);
    send_block(16'h1357, OC, 0, 2'd2, "R4", 0);
    check_lock(1'b0, "R4");
    send_block(16'h9999, OD, 1, 2'd3, "R4", 0);
    check_lock(1'b1, "R4");
    send_block(16'h7E7E, OA, 1, 2'd0, "R4", 0);
    drain("R4");

    // R5: one-bit slip between A and B
    do_reset();
    send_block(16'h4321, OA, 0, 2'd0, "R5", 0);
    send_bit(1'b1);
    send_block(16'h6666, OB, 0, 2'd1, "R5", 0);
    check_lock(1'b0, "R5");
    send_block(16'h1111, OC, 1, 2'd2, "R5", 0);
    check_lock(1'b1, "R5");
    send_block(16'h2222, OD, 1, 2'd3, "R5", 0);
    drain("R5");

    // R9: back-pressure, long hold, input gaps and an idle chunk boundary
    do_reset();
    hold = 1'b1;
    send_block(16'hBEEF, OA, 0, 2'd0, "R9", 0);
    send_block(16'hCAFE, OB, 1, 2'd1, "R9", 0);
    @(negedge clk);
    #1;
    check(out_valid == 1'b1, "R9", "word held under stall", int'(out_valid), 1);
    check(in_ready == 1'b0, "R9", "in_ready during stall", int'(in_ready), 0);
    repeat (6) @(negedge clk);
    #1;
    check(out_data == 16'hCAFE, "R9", "stalled data stable", int'(out_data), 16'hCAFE);
    hold     = 1'b0;
    bp_mode  = 1'b1;
    gap_mode = 1'b1;
    send_block(16'h0123, OC, 1, 2'd2, "R9", 0);
    send_block(16'h4567, OD, 1, 2'd3, "R9", 0);
    repeat (50) @(negedge clk);
    check_lock(1'b1, "R9");
    send_block(16'h89AB, OA, 1, 2'd0, "R9", 0);
    send_block(16'hCDEF, OB, 1, 2'd1, "R9", 0);
    bp_mode  = 1'b0;
    gap_mode = 1'b0;
    drain("R9");

    // R7, R8: bad blocks split across windows, then packed into one
    do_reset();
    send_block(16'h1A2B, OA, 0, 2'd0, "R8", 0);
    send_block(16'h3C4D, OB, 1, 2'd1, "R8", 0);
    send_block(16'h5E6F, OC, 0, 2'd2, "R7", 1);
    send_block(16'h7081, OD, 0, 2'd3, "R7", 1);
    check_lock(1'b1, "R7");
    send_block(16'h1001, OA, 1, 2'd0, "R7", 0);
    send_block(16'h2002, OB, 1, 2'd1, "R7", 0);
    send_block(16'h3003, OC, 1, 2'd2, "R7", 0);
    send_block(16'h4004, OD, 1, 2'd3, "R7", 0);
    send_block(16'h5005, OA, 1, 2'd0, "R8", 0);
    send_block(16'h6006, OB, 1, 2'd1, "R8", 0);
    send_block(16'h7007, OC, 0, 2'd2, "R8", 1);
    send_block(16'h8008, OD, 0, 2'd3, "R8", 1);
    send_block(16'h9009, OA, 1, 2'd0, "R8", 0);
    check_lock(1'b1, "R8");
    send_block(16'hA00A, OB, 0, 2'd1, "R8", 1);
    check_lock(1'b0, "R8");
    drain("R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule